// File: doc/BRIEF.md
# Speculative Page-Crossing Translation Prefetch Trigger

This block sits beside the load/store queue and watches every address that leaves it. When two loads in a row stay inside one 4 KB page and step across a chosen pair of neighbouring cache-line slots near one end of that page, the block predicts that the scan will soon enter the adjacent page. It then asks the page walker to translate that adjacent page ahead of time. The request is a speculative walk and is not tied to any TLB miss. An upward step from line slot 51 to 52 asks for the next page. A downward step from slot 8 to 7 asks for the previous page.

Only one speculative walk can be in flight at a time. Triggers that arrive while the slot is busy are thrown away, and each one raises a drop pulse. The request leaves through a valid/ready channel. The walker answers through a second valid/ready channel. The answer carries the Accessed bit of the final page table entry. If that bit is set, the walk counts as completed. If it is clear, the walk counts as aborted. Every request carries a speculative flag, which tells the walker that it must not write the Accessed bit. Single-cycle pulses report when a walk is issued, completed, aborted or dropped.

Back-pressure rules:
- While `pf_req_valid` is high and `pf_req_ready` is low, the request and its page number are held unchanged.
- A response is taken only on a cycle where both `pf_rsp_valid` and `pf_rsp_ready` are high.
- `pf_rsp_ready` is high only while a handed-over walk is outstanding.

Top module: `tlb_ghost_prefetch`

## Requirements
- R1: A load (`ld_is_store`=0) whose line slot (`ld_vaddr[11:6]`) is 52, following a load to the same page number (`ld_vaddr[47:12]`) at slot 51, raises `pf_req_valid` in the cycle after that load. `pf_req_vpn` is then the page number plus one.
- R2: A load at slot 7 following a load to the same page at slot 8 raises a request in the cycle after it, with `pf_req_vpn` equal to the page number minus one.
- R3: Stores never trigger and leave the load history untouched. A store between the slot-51 load and the slot-52 load of the same page does not stop the trigger.
- R4: These do not trigger: a change of page between the two loads, a jump that is not one slot in the trigger direction (51 to 53), and the reversed steps (52 to 51, 7 to 8).
- R5: An upward trigger on the all-ones page number and a downward trigger on page number 0 are suppressed, because no neighbouring page exists.
- R6: While the request is not accepted, `pf_req_valid` stays high and `pf_req_vpn` stays stable. `pf_req_spec` is 1 whenever a request is presented.
- R7: Only one walk is outstanding. A trigger while a request is presented or a walk is in flight pulses `ev_drop` in the next cycle and leaves the pending page number unchanged.
- R8: A response taken with `pf_rsp_accessed`=1 pulses `ev_done` for one cycle. One taken with `pf_rsp_accessed`=0 pulses `ev_abort` for one cycle. Either way the slot returns to idle.
- R9: `ev_issued` pulses for one cycle, in the cycle after the request handshake.
- R10: With no walk outstanding, `pf_rsp_ready` is 0 and `pf_rsp_valid` has no effect on any event output.
- R11: Reset drives every output to 0, drops a pending request and clears the load history. A slot-52 load as the first load after reset does not trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | An address leaves the load/store queue this cycle |
| ld_is_store | input | 1 | 1 = the access is a store, 0 = a load |
| ld_vaddr | input | 48 | Virtual address of the access |
| pf_req_valid | output | 1 | Speculative walk request presented |
| pf_req_ready | input | 1 | Walker accepts the request |
| pf_req_vpn | output | 36 | Page number to translate |
| pf_req_spec | output | 1 | Speculative flag: the walker must not set the Accessed bit |
| pf_rsp_valid | input | 1 | Walker returns the walk result |
| pf_rsp_ready | output | 1 | A walk is outstanding and its result is accepted |
| pf_rsp_accessed | input | 1 | Accessed bit of the final page table entry |
| ev_issued | output | 1 | Pulse: request handed to the walker |
| ev_done | output | 1 | Pulse: speculative walk completed |
| ev_abort | output | 1 | Pulse: speculative walk aborted on a clear Accessed bit |
| ev_drop | output | 1 | Pulse: trigger discarded because the slot was busy |

## Verification
The bound checker watches four things on every cycle:
- the request hold under back-pressure;
- that nothing starts without a load;
- that a presented request and an outstanding walk never coexist;
- that the issue, completion and abort pulses are exclusive and correctly timed.

The checker also watches that responses outside a walk leave no trace. Other behaviours can only be shown by the bench's scenarios, because the checker does not model slot history or page arithmetic:
- which exact slot pairs fire and which neighbouring page is requested;
- the suppression at both ends of the page-number space;
- that a store in the middle of a scan does not break it;
- that reset forgets the history.

// File: rtl/ghost_pf_pkg.sv
package ghost_pf_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_OFFER = 2'd1,
    SLOT_INFLIGHT = 2'd2
  } slot_state_e;

  localparam int EV_ISSUED = 0;
  localparam int EV_DONE = 1;
  localparam int EV_ABORT = 2;
  localparam int EV_DROP = 3;
  localparam int EV_COUNT = 4;

endpackage

// File: rtl/tgp_step_match.sv
module tgp_step_match #(
  parameter int IDX_W = 6,
  parameter int FROM_IDX = 51,
  parameter int TO_IDX = 52
) (
  input  logic [IDX_W-1:0] prev_idx,
  input  logic [IDX_W-1:0] cur_idx,
  output logic             hit
);
  localparam logic [IDX_W-1:0] FROM_V = IDX_W'(FROM_IDX);
  localparam logic [IDX_W-1:0] TO_V = IDX_W'(TO_IDX);

  always_comb begin
    hit = (prev_idx == FROM_V) && (cur_idx == TO_V);
  end
endmodule

// File: rtl/tgp_line_watch.sv
module tgp_line_watch #(
  parameter int VA_W = 48,
  parameter int PAGE_W = 12,
  parameter int LINE_W = 6,
  parameter int UP_FROM = 51,
  parameter int DN_FROM = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_valid,
  input  logic                     ld_is_store,
  input  logic [VA_W-1:0]          ld_vaddr,
  output logic                     trig,
  output logic [VA_W-PAGE_W-1:0]   trig_vpn
);
  localparam int VPN_W = VA_W - PAGE_W;
  localparam int IDX_W = PAGE_W - LINE_W;
  localparam int NDIR = 2;

  logic             load_seen;
  logic [VPN_W-1:0] cur_vpn;
  logic [IDX_W-1:0] cur_idx;
  logic             hist_vld;
  logic [VPN_W-1:0] hist_vpn;
  logic [IDX_W-1:0] hist_idx;
  logic [NDIR-1:0]  dir_hit;
  logic             same_page;
  logic             up_ok;
  logic             dn_ok;

  always_comb begin
    load_seen = ld_valid && !ld_is_store;
    cur_vpn = ld_vaddr[VA_W-1:PAGE_W];
    cur_idx = ld_vaddr[PAGE_W-1:LINE_W];
  end

  // direction 0 climbs towards the next page, direction 1 descends
  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    localparam int FROM_I = (d == 0) ? UP_FROM : DN_FROM;
    localparam int TO_I = (d == 0) ? UP_FROM + 1 : DN_FROM - 1;
    tgp_step_match #(
      .IDX_W(IDX_W),
      .FROM_IDX(FROM_I),
      .TO_IDX(TO_I)
    ) u_match (
      .prev_idx(hist_idx),
      .cur_idx(cur_idx),
      .hit(dir_hit[d])
    );
  end

  always_comb begin
    same_page = hist_vld && (hist_vpn == cur_vpn);
    up_ok = dir_hit[0] && (cur_vpn != {VPN_W{1'b1}});
    dn_ok = dir_hit[1] && (cur_vpn != {VPN_W{1'b0}});
    trig = load_seen && same_page && (up_ok || dn_ok);
    trig_vpn = up_ok ? cur_vpn + VPN_W'(1) : cur_vpn - VPN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_vld <= 1'b0;
      hist_vpn <= '0;
      hist_idx <= '0;
    end else if (load_seen) begin
      hist_vld <= 1'b1;
      hist_vpn <= cur_vpn;
      hist_idx <= cur_idx;
    end
  end
endmodule

// File: rtl/tgp_walk_slot.sv
module tgp_walk_slot
  import ghost_pf_pkg::*;
#(
  parameter int VPN_W = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [VPN_W-1:0] trig_vpn,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [VPN_W-1:0] req_vpn,
  output logic             req_spec,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic             rsp_accessed,
  output logic [EV_COUNT-1:0] fire
);
  slot_state_e      state_q, state_d;
  logic [VPN_W-1:0] vpn_q;
  logic             spec_q;
  logic             take_req;
  logic             take_rsp;

  always_comb begin
    req_valid = (state_q == SLOT_OFFER);
    rsp_ready = (state_q == SLOT_INFLIGHT);
    req_vpn = vpn_q;
    req_spec = spec_q && req_valid;
    take_req = req_valid && req_ready;
    take_rsp = rsp_ready && rsp_valid;
    state_d = state_q;
    case (state_q)
      SLOT_IDLE:     if (trig) state_d = SLOT_OFFER;
      SLOT_OFFER:    if (take_req) state_d = SLOT_INFLIGHT;
      SLOT_INFLIGHT: if (take_rsp) state_d = SLOT_IDLE;
      default:       state_d = SLOT_IDLE;
    endcase
    fire = '0;
    fire[EV_ISSUED] = take_req;
    fire[EV_DONE] = take_rsp && rsp_accessed;
    fire[EV_ABORT] = take_rsp && !rsp_accessed;
    fire[EV_DROP] = trig && (state_q != SLOT_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SLOT_IDLE;
      vpn_q <= '0;
      spec_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == SLOT_IDLE && trig) begin
        vpn_q <= trig_vpn;
        spec_q <= 1'b1;
      end else if (take_rsp) begin
        spec_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tgp_event_reg.sv
module tgp_event_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fire,
  output logic [N-1:0] pulse
);
  for (genvar i = 0; i < N; i++) begin : g_ev
    always_ff @(posedge clk) begin
      if (!rst_n) pulse[i] <= 1'b0;
      else        pulse[i] <= fire[i];
    end
  end
endmodule

// File: rtl/tlb_ghost_prefetch.sv
module tlb_ghost_prefetch
  import ghost_pf_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PAGE_W = 12,
  parameter int LINE_W = 6,
  parameter int UP_FROM = 51,
  parameter int DN_FROM = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_valid,
  input  logic                   ld_is_store,
  input  logic [VA_W-1:0]        ld_vaddr,
  output logic                   pf_req_valid,
  input  logic                   pf_req_ready,
  output logic [VA_W-PAGE_W-1:0] pf_req_vpn,
  output logic                   pf_req_spec,
  input  logic                   pf_rsp_valid,
  output logic                   pf_rsp_ready,
  input  logic                   pf_rsp_accessed,
  output logic                   ev_issued,
  output logic                   ev_done,
  output logic                   ev_abort,
  output logic                   ev_drop
);
  localparam int VPN_W = VA_W - PAGE_W;

  logic                trig;
  logic [VPN_W-1:0]    trig_vpn;
  logic [EV_COUNT-1:0] fire;
  logic [EV_COUNT-1:0] pulse;

  tgp_line_watch #(
    .VA_W(VA_W), .PAGE_W(PAGE_W), .LINE_W(LINE_W),
    .UP_FROM(UP_FROM), .DN_FROM(DN_FROM)
  ) u_watch (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_is_store(ld_is_store), .ld_vaddr(ld_vaddr),
    .trig(trig), .trig_vpn(trig_vpn)
  );

  tgp_walk_slot #(.VPN_W(VPN_W)) u_slot (
    .clk(clk), .rst_n(rst_n),
    .trig(trig), .trig_vpn(trig_vpn),
    .req_valid(pf_req_valid), .req_ready(pf_req_ready),
    .req_vpn(pf_req_vpn), .req_spec(pf_req_spec),
    .rsp_valid(pf_rsp_valid), .rsp_ready(pf_rsp_ready),
    .rsp_accessed(pf_rsp_accessed),
    .fire(fire)
  );

  tgp_event_reg #(.N(EV_COUNT)) u_ev (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pulse(pulse)
  );

  always_comb begin
    ev_issued = pulse[EV_ISSUED];
    ev_done = pulse[EV_DONE];
    ev_abort = pulse[EV_ABORT];
    ev_drop = pulse[EV_DROP];
  end
endmodule

// File: rtl/tlb_ghost_prefetch_chk.sv
module tlb_ghost_prefetch_chk #(
  parameter int VPN_W = 36
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_valid,
  input logic             ld_is_store,
  input logic             pf_req_valid,
  input logic             pf_req_ready,
  input logic [VPN_W-1:0] pf_req_vpn,
  input logic             pf_rsp_valid,
  input logic             pf_rsp_ready,
  input logic             ev_issued,
  input logic             ev_done,
  input logic             ev_abort
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req_valid && !pf_req_ready |=> pf_req_valid && $stable(pf_req_vpn)); // R6

  AST_NO_STORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_req_valid && !(ld_valid && !ld_is_store) |=> !pf_req_valid); // R3

  AST_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !(pf_req_valid && pf_rsp_ready)); // R7

  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_issued, ev_done, ev_abort})); // R8

  AST_DONE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    pf_rsp_valid && pf_rsp_ready |=> !pf_rsp_ready && !pf_req_valid); // R8

  AST_ISSUE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pf_req_valid && pf_req_ready |=> ev_issued); // R9

  AST_RSP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !pf_rsp_ready |=> !ev_done && !ev_abort); // R10
endmodule

bind tlb_ghost_prefetch tlb_ghost_prefetch_chk #(.VPN_W(VA_W - PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ld_valid(ld_valid), .ld_is_store(ld_is_store),
  .pf_req_valid(pf_req_valid), .pf_req_ready(pf_req_ready),
  .pf_req_vpn(pf_req_vpn),
  .pf_rsp_valid(pf_rsp_valid), .pf_rsp_ready(pf_rsp_ready),
  .ev_issued(ev_issued), .ev_done(ev_done), .ev_abort(ev_abort)
);

// File: tb/tlb_ghost_prefetch_test.sv
module tlb_ghost_prefetch_test;
  localparam int VPN_W = 36;
  localparam int NVEC = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0;
  logic ld_is_store = 1'b0;
  logic [47:0] ld_vaddr = '0;
  logic pf_req_valid, pf_req_ready = 1'b0;
  logic [VPN_W-1:0] pf_req_vpn;
  logic pf_req_spec;
  logic pf_rsp_valid = 1'b0, pf_rsp_ready, pf_rsp_accessed = 1'b0;
  logic ev_issued, ev_done, ev_abort, ev_drop;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tlb_ghost_prefetch uut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_is_store(ld_is_store), .ld_vaddr(ld_vaddr),
    .pf_req_valid(pf_req_valid), .pf_req_ready(pf_req_ready),
    .pf_req_vpn(pf_req_vpn), .pf_req_spec(pf_req_spec),
    .pf_rsp_valid(pf_rsp_valid), .pf_rsp_ready(pf_rsp_ready),
    .pf_rsp_accessed(pf_rsp_accessed),
    .ev_issued(ev_issued), .ev_done(ev_done), .ev_abort(ev_abort),
    .ev_drop(ev_drop)
  );

  // entry: store, page[16], slot[6], expect request, expected page[16], accessed bit
  localparam logic [40:0] VEC [NVEC] = '{
    {1'b0, 16'd5, 6'd52, 1'b0, 16'd0,  1'b0},
    {1'b0, 16'd5, 6'd51, 1'b0, 16'd0,  1'b0},
    {1'b0, 16'd5, 6'd52, 1'b1, 16'd6,  1'b1},
    {1'b0, 16'd9, 6'd8,  1'b0, 16'd0,  1'b0},
    {1'b0, 16'd9, 6'd7,  1'b1, 16'd8,  1'b0},
    {1'b0, 16'd9, 6'd51, 1'b0, 16'd0,  1'b0},
    {1'b1, 16'd9, 6'd20, 1'b0, 16'd0,  1'b0},
    {1'b0, 16'd9, 6'd52, 1'b1, 16'd10, 1'b1},
    {1'b0, 16'd9, 6'd51, 1'b0, 16'd0,  1'b0},
    {1'b0, 16'd9, 6'd53, 1'b0, 16'd0,  1'b0},
    {1'b0, 16'd3, 6'd8,  1'b0, 16'd0,  1'b0},
    {1'b0, 16'd4, 6'd7,  1'b0, 16'd0,  1'b0},
    {1'b0, 16'd4, 6'd52, 1'b0, 16'd0,  1'b0},
    {1'b0, 16'd4, 6'd51, 1'b0, 16'd0,  1'b0},
    {1'b0, 16'd4, 6'd7,  1'b0, 16'd0,  1'b0},
    {1'b0, 16'd4, 6'd8,  1'b0, 16'd0,  1'b0},
    {1'b0, 16'd4, 6'd7,  1'b1, 16'd3,  1'b1}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic st, input logic [VPN_W-1:0] vpn, input logic [5:0] idx);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_is_store = st;
    ld_vaddr = {vpn, idx, 6'd0};
    @(negedge clk);
    ld_valid = 1'b0;
    ld_is_store = 1'b0;
  endtask

  task automatic do_walk(input logic acc, input string tag);
    pf_req_ready = 1'b1;
    @(negedge clk);
    pf_req_ready = 1'b0;
    chk({tag, " R9 issued pulse"}, 64'(ev_issued), 64'd1);
    chk({tag, " R7 in flight"}, 64'(pf_rsp_ready), 64'd1);
    pf_rsp_valid = 1'b1;
    pf_rsp_accessed = acc;
    @(negedge clk);
    pf_rsp_valid = 1'b0;
    chk({tag, " R8 done pulse"}, 64'(ev_done), 64'(acc));
    chk({tag, " R8 abort pulse"}, 64'(ev_abort), 64'(!acc));
    chk({tag, " R8 back to idle"}, 64'(pf_rsp_ready), 64'd0);
    @(negedge clk);
    chk({tag, " R8 pulse single"}, 64'(ev_done | ev_abort), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset req_valid", 64'(pf_req_valid), 64'd0);
    chk("R11 reset events", 64'({ev_issued, ev_done, ev_abort, ev_drop, pf_rsp_ready}), 64'd0);
    rst_n = 1'b1;

    // vector table: R1 R2 R3 R4 R8 R11
    for (int i = 0; i < NVEC; i++) begin
      logic [40:0] v;
      string tg;
      v = VEC[i];
      tg = $sformatf("vec%0d R1/R2/R3/R4", i);
      do_load(v[40], VPN_W'(v[39:24]), v[23:18]);
      chk(tg, 64'(pf_req_valid), 64'(v[17]));
      if (v[17]) begin
        chk({tg, " page"}, 64'(pf_req_vpn), 64'(v[16:1]));
        chk({tg, " R6 spec flag"}, 64'(pf_req_spec), 64'd1);
        do_walk(v[0], tg);
      end
    end

    // R6 and R7: hold under back-pressure, then a dropped trigger
    do_load(1'b0, 36'd20, 6'd51);
    do_load(1'b0, 36'd20, 6'd52);
    repeat (3) @(negedge clk);
    chk("R6 held valid", 64'(pf_req_valid), 64'd1);
    chk("R6 held page", 64'(pf_req_vpn), 64'd21);
    do_load(1'b0, 36'd20, 6'd51);
    do_load(1'b0, 36'd20, 6'd52);
    chk("R7 drop pulse", 64'(ev_drop), 64'd1);
    chk("R7 page kept", 64'(pf_req_vpn), 64'd21);
    @(negedge clk);
    chk("R7 drop single", 64'(ev_drop), 64'd0);
    do_walk(1'b0, "R7 walk");

    // R10: response with no walk outstanding
    pf_rsp_valid = 1'b1;
    pf_rsp_accessed = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 rsp_ready low", 64'(pf_rsp_ready), 64'd0);
    chk("R10 no done", 64'(ev_done | ev_abort), 64'd0);
    pf_rsp_valid = 1'b0;
    @(negedge clk);
    chk("R10 still none", 64'(ev_done | ev_abort | ev_issued), 64'd0);

    // R5: no neighbour at the ends of page-number space
    do_load(1'b0, {VPN_W{1'b1}}, 6'd51);
    do_load(1'b0, {VPN_W{1'b1}}, 6'd52);
    chk("R5 top page", 64'(pf_req_valid), 64'd0);
    do_load(1'b0, 36'd0, 6'd8);
    do_load(1'b0, 36'd0, 6'd7);
    chk("R5 page zero", 64'(pf_req_valid), 64'd0);

    // R11: reset drops a pending request and clears history
    do_load(1'b0, 36'd30, 6'd51);
    do_load(1'b0, 36'd30, 6'd52);
    chk("R11 pending before reset", 64'(pf_req_valid), 64'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset drops request", 64'(pf_req_valid), 64'd0);
    rst_n = 1'b1;
    do_load(1'b0, 36'd30, 6'd52);
    chk("R11 history cleared", 64'(pf_req_valid), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule